// File: doc/BRIEF.md
# Prioritized Port Pin Multiplexer

This block controls an eight-pin general-purpose port whose pins are shared with several on-chip peripherals. For every pin it chooses one owner from a fixed ranking: a chip-select line comes first, then a PWM channel, then a serial function (either of two two-wire buses or an asynchronous receive/transmit pair), and last the general-purpose latch. The owner sets the pin's output value and its output enable. Pin levels pass through a two-flop synchronizer before they reach the peripherals' inputs and the register read path.

Software sees two registers, chosen by `reg_sel`. A 0 selects the output latch, and a 1 selects the direction register, where a 1 bit marks an output. Reading the latch returns the latched bit on output pins and the synchronized pin level on input pins. The latch can be written at any time, including while a peripheral owns the pin. Each two-wire bus and the asynchronous pair has an alternate-routing bit. When that bit is 1 the function does not claim these pins.

Top module: `pin_owner_mux`

## Requirements
- R1: Ranking is chip select > PWM > serial > GPIO. Chip select 2 (`cs_en[1]`) owns pin 7 and chip select 0 (`cs_en[0]`) owns pin 6. An owning chip select drives its value with output enable 1.
- R2: A pin whose PWM channel is enabled, and which no chip select owns, drives `pwm_val[i]` with output enable 1.
- R3: When `pwm_en[7]` and `pwm7_listen` are both 1 and no chip select owns pin 7, pin 7 becomes an input: output enable 0, output 0, and `pwm7_in` follows the synchronized pin 7. In every other case `pwm7_in` is 0.
- R4: Bus 1 uses pins 7 (clock) and 6 (data), and bus 0 uses pins 5 (clock) and 4 (data). A bus pin is owned when the bus is enabled, its alt bit is 0 and no higher-ranked function claims the pin. An owned bus pin drives 0, with output enable equal to the inverse of the drive value. The bus inputs return the synchronized pin level when the pin is owned, and 1 otherwise.
- R5: The asynchronous pair is active only when receive enable and transmit enable are both 1 and `uart_alt` is 0. Pin 2 is then receive: output enable 0, and `uart_rxd` gets the synchronized pin. Pin 0 is then transmit and drives `uart_txd`. Each pin checks only its own PWM channel. `uart_rxd` is 1 when pin 2 is not owned by receive.
- R6: A GPIO-owned pin drives its latch bit, with output enable equal to its direction bit.
- R7: With `reg_sel`=0, a read returns the latch bit where the direction bit is 1 and the synchronized pin where it is 0. With `reg_sel`=1, a read returns the direction register. A write with `reg_wr`=1 takes effect at the clock edge.
- R8: A latch write while a peripheral owns the pin is stored, and it appears on the pin once GPIO owns the pin again.
- R9: After reset the latch and the direction register are 0. With all peripheral enables low, every output enable is then 0.
- R10: A change on `pin_in` shows in a latch read after exactly two rising clock edges.
- R11: A set alt bit keeps the bus or asynchronous pair off its pins, and those pins fall back to GPIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects the latch, 1 selects the direction register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the register chosen by `reg_sel` |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| cs_en | input | 2 | Chip-select enables ([1] is CS2 on pin 7, [0] is CS0 on pin 6) |
| cs_val | input | 2 | Chip-select output values |
| pwm_en | input | 8 | PWM channel enables |
| pwm_val | input | 8 | PWM channel outputs |
| pwm7_listen | input | 1 | Turns channel 7 into an input |
| pwm7_in | output | 1 | Synchronized pin 7 for channel 7 |
| twi0_en | input | 1 | Bus 0 enable |
| twi0_alt | input | 1 | Bus 0 alternate routing |
| twi0_scl_drv | input | 1 | Bus 0 clock drive (0 pulls low) |
| twi0_sda_drv | input | 1 | Bus 0 data drive (0 pulls low) |
| twi0_scl_in | output | 1 | Bus 0 clock input |
| twi0_sda_in | output | 1 | Bus 0 data input |
| twi1_en | input | 1 | Bus 1 enable |
| twi1_alt | input | 1 | Bus 1 alternate routing |
| twi1_scl_drv | input | 1 | Bus 1 clock drive |
| twi1_sda_drv | input | 1 | Bus 1 data drive |
| twi1_scl_in | output | 1 | Bus 1 clock input |
| twi1_sda_in | output | 1 | Bus 1 data input |
| uart_rx_en | input | 1 | Receiver enable |
| uart_tx_en | input | 1 | Transmitter enable |
| uart_alt | input | 1 | Alternate routing for the asynchronous pair |
| uart_txd | input | 1 | Transmit data |
| uart_rxd | output | 1 | Receive data |

## Verification
A latch write can land in the same cycle in which a peripheral owns the pin. The bench provokes this by writing the latch while every PWM channel is enabled. It first checks that the pins still show the PWM values, then drops the PWM enables and checks that the pins now show the written latch value. Ranking collisions are provoked through vectors that enable a chip select, PWM channels and serial functions on the same pins in the same cycle. Each vector is judged against hand-derived output and output-enable bytes.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
  localparam int PINS = 8;

  typedef enum logic [2:0] {
    OWN_GPIO,
    OWN_SER_IN,
    OWN_SER_OUT,
    OWN_TWI,
    OWN_PWM_OUT,
    OWN_PWM_IN,
    OWN_CS
  } owner_e;

  // Fixed ranking: chip select, PWM, serial, GPIO.
  function automatic owner_e pick_owner(input logic cs_req, input logic pwm_req,
                                        input logic pwm_listen, input logic twi_req,
                                        input logic sin_req, input logic sout_req);
    if (cs_req)   return OWN_CS;
    if (pwm_req)  return pwm_listen ? OWN_PWM_IN : OWN_PWM_OUT;
    if (twi_req)  return OWN_TWI;
    if (sin_req)  return OWN_SER_IN;
    if (sout_req) return OWN_SER_OUT;
    return OWN_GPIO;
  endfunction

  // Output pins report the latch, input pins report the live level.
  function automatic logic [PINS-1:0] merge_read(input logic [PINS-1:0] dir,
                                                 input logic [PINS-1:0] latch,
                                                 input logic [PINS-1:0] live);
    return (dir & latch) | (~dir & live);
  endfunction
endpackage

// File: rtl/pmux_sync.sv
module pmux_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pmux_regs.sv
module pmux_regs
  import pmux_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_sel,
  input  logic            reg_wr,
  input  logic [PINS-1:0] reg_wdata,
  input  logic [PINS-1:0] live,
  output logic [PINS-1:0] reg_rdata,
  output logic [PINS-1:0] latch_q,
  output logic [PINS-1:0] dir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (reg_wr) begin
      if (reg_sel) dir_q   <= reg_wdata;
      else         latch_q <= reg_wdata;
    end
  end

  assign reg_rdata = reg_sel ? dir_q : merge_read(dir_q, latch_q, live);
endmodule

// File: rtl/pmux_owner.sv
module pmux_owner
  import pmux_pkg::*;
(
  input  logic [PINS-1:0] cs_req,
  input  logic [PINS-1:0] pwm_req,
  input  logic [PINS-1:0] pwm_listen,
  input  logic [PINS-1:0] twi_req,
  input  logic [PINS-1:0] sin_req,
  input  logic [PINS-1:0] sout_req,
  input  logic [PINS-1:0] cs_bit,
  input  logic [PINS-1:0] pwm_bit,
  input  logic [PINS-1:0] twi_bit,
  input  logic [PINS-1:0] sout_bit,
  input  logic [PINS-1:0] latch_q,
  input  logic [PINS-1:0] dir_q,
  output owner_e          own [PINS],
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic o, e;
    assign own[p] = pick_owner(cs_req[p], pwm_req[p], pwm_listen[p],
                               twi_req[p], sin_req[p], sout_req[p]);
    always_comb begin
      unique case (own[p])
        OWN_CS:      begin o = cs_bit[p];   e = 1'b1;        end
        OWN_PWM_OUT: begin o = pwm_bit[p];  e = 1'b1;        end
        OWN_PWM_IN:  begin o = 1'b0;        e = 1'b0;        end
        OWN_TWI:     begin o = 1'b0;        e = ~twi_bit[p]; end
        OWN_SER_IN:  begin o = 1'b0;        e = 1'b0;        end
        OWN_SER_OUT: begin o = sout_bit[p]; e = 1'b1;        end
        default:     begin o = latch_q[p];  e = dir_q[p];    end
      endcase
    end
    assign pin_out[p] = o;
    assign pin_oe[p]  = e;
  end
endmodule

// File: rtl/pin_owner_mux.sv
module pin_owner_mux
  import pmux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  input  logic [1:0] cs_en,
  input  logic [1:0] cs_val,
  input  logic [7:0] pwm_en,
  input  logic [7:0] pwm_val,
  input  logic       pwm7_listen,
  output logic       pwm7_in,
  input  logic       twi0_en,
  input  logic       twi0_alt,
  input  logic       twi0_scl_drv,
  input  logic       twi0_sda_drv,
  output logic       twi0_scl_in,
  output logic       twi0_sda_in,
  input  logic       twi1_en,
  input  logic       twi1_alt,
  input  logic       twi1_scl_drv,
  input  logic       twi1_sda_drv,
  output logic       twi1_scl_in,
  output logic       twi1_sda_in,
  input  logic       uart_rx_en,
  input  logic       uart_tx_en,
  input  logic       uart_alt,
  input  logic       uart_txd,
  output logic       uart_rxd
);
  logic [PINS-1:0] live, latch_q, dir_q;
  logic [PINS-1:0] cs_req, twi_req, sin_req, sout_req, listen;
  logic [PINS-1:0] cs_bit, twi_bit, sout_bit;
  owner_e          own [PINS];
  // Named ownership events for the checker.
  logic [PINS-1:0] twi_owned, pwm_in_owned, ser_in_owned;
  logic            twi0_live, twi1_live, uart_live;

  assign twi0_live = twi0_en & ~twi0_alt;
  assign twi1_live = twi1_en & ~twi1_alt;
  assign uart_live = uart_rx_en & uart_tx_en & ~uart_alt;

  assign cs_req   = {cs_en[1], cs_en[0], 6'b0};
  assign cs_bit   = {cs_val[1], cs_val[0], 6'b0};
  assign twi_req  = {twi1_live, twi1_live, twi0_live, twi0_live, 4'b0};
  assign twi_bit  = {twi1_scl_drv, twi1_sda_drv, twi0_scl_drv, twi0_sda_drv, 4'b0};
  assign sin_req  = {5'b0, uart_live, 2'b0};
  assign sout_req = {7'b0, uart_live};
  assign sout_bit = {7'b0, uart_txd};
  assign listen   = {pwm7_listen, 7'b0};

  pmux_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(live)
  );

  pmux_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .live(live), .reg_rdata(reg_rdata),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  pmux_owner u_owner (
    .cs_req(cs_req), .pwm_req(pwm_en), .pwm_listen(listen), .twi_req(twi_req),
    .sin_req(sin_req), .sout_req(sout_req), .cs_bit(cs_bit), .pwm_bit(pwm_val),
    .twi_bit(twi_bit), .sout_bit(sout_bit), .latch_q(latch_q), .dir_q(dir_q),
    .own(own), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_flag
    assign twi_owned[p]    = (own[p] == OWN_TWI);
    assign pwm_in_owned[p] = (own[p] == OWN_PWM_IN);
    assign ser_in_owned[p] = (own[p] == OWN_SER_IN);
  end

  assign pwm7_in     = pwm_in_owned[7] & live[7];
  assign twi1_scl_in = twi_owned[7] ? live[7] : 1'b1;
  assign twi1_sda_in = twi_owned[6] ? live[6] : 1'b1;
  assign twi0_scl_in = twi_owned[5] ? live[5] : 1'b1;
  assign twi0_sda_in = twi_owned[4] ? live[4] : 1'b1;
  assign uart_rxd    = ser_in_owned[2] ? live[2] : 1'b1;
endmodule

// File: rtl/pin_owner_mux_chk.sv
module pin_owner_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [7:0] pin_out,
  input logic [7:0] pin_oe,
  input logic [1:0] cs_en,
  input logic [1:0] cs_val,
  input logic [7:0] pwm_en,
  input logic [7:0] pwm_val,
  input logic       pwm7_listen,
  input logic       twi1_alt,
  input logic       twi1_scl_drv,
  input logic       uart_rx_en,
  input logic       uart_tx_en,
  input logic       uart_alt,
  input logic       uart_txd,
  input logic [7:0] twi_owned
);
  assert_cs_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_en[1] |-> (pin_oe[7] && pin_out[7] == cs_val[1]));

  assert_pwm_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en[3] |-> (pin_oe[3] && pin_out[3] == pwm_val[3]));

  assert_pwm7_listen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en[7] && pwm7_listen && !cs_en[1]) |-> !pin_oe[7]);

  assert_twi_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    twi_owned[7] |-> (!pin_out[7] && pin_oe[7] == !twi1_scl_drv));

  assert_uart_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_rx_en && uart_tx_en && !uart_alt && !pwm_en[0]) |->
      (pin_oe[0] && pin_out[0] == uart_txd));

  assert_dir_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> (!reg_sel || reg_rdata == $past(reg_wdata)));

  assert_alt_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    twi1_alt |-> (!twi_owned[7] && !twi_owned[6]));
endmodule

bind pin_owner_mux pin_owner_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .cs_en(cs_en), .cs_val(cs_val), .pwm_en(pwm_en),
  .pwm_val(pwm_val), .pwm7_listen(pwm7_listen), .twi1_alt(twi1_alt),
  .twi1_scl_drv(twi1_scl_drv), .uart_rx_en(uart_rx_en),
  .uart_tx_en(uart_tx_en), .uart_alt(uart_alt), .uart_txd(uart_txd),
  .twi_owned(twi_owned)
);

// File: tb/tb_pin_owner_mux.sv
`timescale 1ns/1ps
module tb_pin_owner_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata, pin_in = '0, pin_out, pin_oe;
  logic [1:0] cs_en = '0, cs_val = '0;
  logic [7:0] pwm_en = '0, pwm_val = '0;
  logic pwm7_listen = 1'b0, pwm7_in;
  logic twi0_en = 0, twi0_alt = 0, twi0_scl_drv = 0, twi0_sda_drv = 0, twi0_scl_in, twi0_sda_in;
  logic twi1_en = 0, twi1_alt = 0, twi1_scl_drv = 0, twi1_sda_drv = 0, twi1_scl_in, twi1_sda_in;
  logic uart_rx_en = 0, uart_tx_en = 0, uart_alt = 0, uart_txd = 0, uart_rxd;

  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  pin_owner_mux dut (.*);

  typedef struct packed {
    logic [1:0] cs; logic [7:0] pwm; logic sd;
    logic t0, t0a, t1, t1a, rx, tx, ua;
    logic [7:0] oe, out;
  } vec_t;

  // Fixed drives: latch A5, dir 3C, pwm_val 5A, cs_val 10,
  // bus1 scl/sda drive 1/0, bus0 scl/sda drive 0/1, txd 1.
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hA5},
    '{2'b00, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h5A},
    '{2'b11, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h9A},
    '{2'b00, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h25},
    '{2'b00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h6C, 8'h05},
    '{2'b00, 8'h90, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFC, 8'h15},
    '{2'b00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h2C, 8'h85},
    '{2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h39, 8'hA1},
    '{2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hA5},
    '{2'b00, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h39, 8'hA0},
    '{2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h3C, 8'hA5},
    '{2'b01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h7C, 8'h25}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] val);
    @(negedge clk);
    reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    #2;
  endtask

  task automatic rd(input logic sel, output logic [7:0] val);
    reg_sel = sel;
    #1;
    val = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic clear_en();
    cs_en = '0; pwm_en = '0; pwm7_listen = 0;
    twi0_en = 0; twi0_alt = 0; twi1_en = 0; twi1_alt = 0;
    uart_rx_en = 0; uart_tx_en = 0; uart_alt = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R9: reset state
    chk("R9 oe after reset", pin_oe, 8'h00);
    rd(1'b1, rv); chk("R9 dir after reset", rv, 8'h00);
    wr(1'b1, 8'hFF);
    rd(1'b0, rv); chk("R9 latch after reset", rv, 8'h00);

    // Vector table: R1 R2 R3 R4 R5 R6 R11
    wr(1'b0, 8'hA5);
    wr(1'b1, 8'h3C);
    pwm_val = 8'h5A; cs_val = 2'b10;
    twi1_scl_drv = 1; twi1_sda_drv = 0; twi0_scl_drv = 0; twi0_sda_drv = 1;
    uart_txd = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cs_en = VEC[i].cs; pwm_en = VEC[i].pwm; pwm7_listen = VEC[i].sd;
      twi0_en = VEC[i].t0; twi0_alt = VEC[i].t0a;
      twi1_en = VEC[i].t1; twi1_alt = VEC[i].t1a;
      uart_rx_en = VEC[i].rx; uart_tx_en = VEC[i].tx; uart_alt = VEC[i].ua;
      #2;
      chk($sformatf("R1 R2 R4 R5 R6 R11 vec %0d oe", i), pin_oe, VEC[i].oe);
      chk($sformatf("R1 R2 R3 R4 R5 R6 R11 vec %0d out", i), pin_out, VEC[i].out);
    end
    clear_en();

    // R10: two-edge synchronizer latency
    wr(1'b1, 8'h00);
    pin_in = 8'h00;
    cyc(3);
    pin_in = 8'h5C;
    rd(1'b0, rv); chk("R10 zero edges", rv, 8'h00);
    cyc(1); rd(1'b0, rv); chk("R10 one edge", rv, 8'h00);
    cyc(1); rd(1'b0, rv); chk("R10 two edges", rv, 8'h5C);

    // R7: mixed read
    wr(1'b1, 8'h0F);
    wr(1'b0, 8'h33);
    pin_in = 8'hC0;
    cyc(3);
    rd(1'b0, rv); chk("R7 mixed read", rv, 8'hC3);
    rd(1'b1, rv); chk("R7 dir read", rv, 8'h0F);

    // R8: latch write while PWM owns all pins
    pwm_en = 8'hFF;
    wr(1'b0, 8'h77);
    chk("R8 pwm keeps pins", pin_out, 8'h5A);
    pwm_en = 8'h00;
    wr(1'b1, 8'hFF);
    chk("R8 latch on pins", pin_out, 8'h77);
    rd(1'b0, rv); chk("R8 latch read", rv, 8'h77);

    // R3: channel 7 as input
    wr(1'b1, 8'h00);
    pwm_en = 8'h80; pwm7_listen = 1; pin_in = 8'h80;
    cyc(3);
    chk("R3 pwm7_in follows pin", {7'b0, pwm7_in}, 8'h01);
    chk("R3 pin7 released", {7'b0, pin_oe[7]}, 8'h00);
    pwm_en = 8'h00; #1;
    chk("R3 pwm7_in idle", {7'b0, pwm7_in}, 8'h00);
    clear_en();

    // R4: bus input routing
    twi0_en = 1; pin_in = 8'h00;
    cyc(3);
    chk("R4 bus0 inputs owned", {6'b0, twi0_scl_in, twi0_sda_in}, 8'h00);
    twi0_alt = 1; #1;
    chk("R4 R11 bus0 inputs idle", {6'b0, twi0_scl_in, twi0_sda_in}, 8'h03);
    clear_en();

    // R5: receive routing
    uart_rx_en = 1; uart_tx_en = 1;
    cyc(1);
    chk("R5 rxd owned", {7'b0, uart_rxd}, 8'h00);
    uart_tx_en = 0; #1;
    chk("R5 rxd idle", {7'b0, uart_rxd}, 8'h01);
    clear_en();

    finish_run();
  end
endmodule